// File: doc/BRIEF.md
# Multi-Mode Cycle Interrupt Timer

This block is a 16-bit interrupt timer driven by a one-cycle tick strobe. In a typical system the strobe fires once per processor cycle. On each tick the counter moves according to one of seven behaviours, chosen by a 3-bit mode input:

- Four behaviours count up:
  - a level compare against a masked counter
  - fire and return to zero
  - fire once and disable
  - fire at one count and clear itself at a later count
- Three behaviours count down:
  - stop at zero
  - test for zero before decrementing, then disable
  - wrap freely and fire on underflow

The interrupt line `irq_o` always shows the pending flag.

Software-side state is changed through a plain register-write port: a write strobe, a 3-bit command select and a 16-bit data word. Through this port a host can set the counter, the reload value, the enable flag and the pending flag. It can also copy the reload value into the counter, or acknowledge the interrupt. The mode, threshold, mask, fire count and clear count are static configuration inputs. The counter and enable flag are brought out as read-back ports so that a host can sample them. All control pins are plain level or strobe signals. There is no flow control: a write is accepted in the cycle its strobe is high.

Top module: `cyc_irq_timer`

## Requirements
- R1: After reset, `count_o`, the reload value, `enable_o` and `irq_o` are all zero.
- R2: The write command select codes are:
  - 0 loads the counter from `wr_data_i`
  - 1 loads the reload value
  - 2 sets enable from `wr_data_i[0]`
  - 3 sets pending from `wr_data_i[0]`
  - 4 copies the reload value into the counter
  - 5 clears pending
  
  When a write and a tick arrive in the same cycle, the write takes effect and that tick is discarded.
- R3: Mode 0, while enabled: each tick makes the counter (counter+1) AND `mask_i`. Pending then becomes (new counter >= `thresh_i`), so it drops again once the masked count wraps below the threshold.
- R4: Mode 1, while enabled: each tick increments the counter. When the new value is >= `thresh_i`, the counter becomes 0 and pending is set.
- R5: Mode 2, while enabled: each tick increments the counter. When the new value equals `thresh_i`, pending is set and enable is cleared.
- R6: Mode 3, while enabled: each tick increments the counter. Pending is set when the new value equals `fire_cnt_i`. Otherwise, pending is cleared when the new value equals `ack_cnt_i`.
- R7: Mode 4: a tick does nothing when disabled or when the counter is 0. Otherwise the counter decrements, and pending is set when the result is 0.
- R8: Mode 5, while enabled: a tick that finds the counter at 0 sets pending and clears enable, with no decrement. Any other tick decrements the counter. A counter loaded with 5 therefore fires on the sixth tick.
- R9: Mode 6: every tick decrements the counter with wraparound, whether or not the block is enabled. Pending is set on the step from 0 to 0xFFFF, and only when enable is 1.
- R10: In modes 0 to 5, a cleared enable holds the counter and pending unchanged across ticks.
- R11: The acknowledge command (code 5) clears `irq_o` on the next cycle. The reload command (code 4) makes `count_o` equal to the last reload value written.
- R12: Mode code 7 ignores ticks: counter, enable and pending stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle advance strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write command select |
| wr_data_i | input | 16 | Write data |
| mode_i | input | 3 | Counting behaviour select |
| thresh_i | input | 16 | Compare threshold for modes 0 to 2 |
| mask_i | input | 16 | Counter mask for mode 0 |
| fire_cnt_i | input | 16 | Set-pending count for mode 3 |
| ack_cnt_i | input | 16 | Clear-pending count for mode 3 |
| irq_o | output | 1 | Interrupt request (pending flag) |
| count_o | output | 16 | Counter read-back |
| enable_o | output | 1 | Enable flag read-back |

## Verification
Every state element is visible one cycle after the edge that changes it: the counter on `count_o`, enable on `enable_o` and pending on `irq_o`. An off-by-one in a compare, or a zero test placed on the wrong side of a decrement, therefore shows as an interrupt one tick early or late at a count the bench knows in advance. A lost write or a wrong priority between write and tick appears as a stray count on the cycle after the collision. Enable gating done wrong shows as counter movement that should not happen, visible across the next few ticks.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;

  localparam int CNT_W = 16;

  typedef enum logic [2:0] {
    MODE_UP_LEVEL   = 3'd0,
    MODE_UP_WRAP0   = 3'd1,
    MODE_UP_ONESHOT = 3'd2,
    MODE_UP_WINDOW  = 3'd3,
    MODE_DN_STOP    = 3'd4,
    MODE_DN_ONESHOT = 3'd5,
    MODE_DN_FREE    = 3'd6,
    MODE_IDLE       = 3'd7
  } irq_mode_e;

  typedef enum logic [2:0] {
    CMD_SET_CNT    = 3'd0,
    CMD_SET_RELOAD = 3'd1,
    CMD_SET_EN     = 3'd2,
    CMD_SET_PEND   = 3'd3,
    CMD_LOAD       = 3'd4,
    CMD_ACK        = 3'd5
  } irq_cmd_e;

endpackage

// File: rtl/cyc_irq_step.sv
// Next-state logic for one tick in the selected counting behaviour.
module cyc_irq_step
  import cyc_irq_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic [W-1:0] cnt,
  input  logic         en,
  input  logic         pend,
  input  logic [W-1:0] thresh,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] fire_cnt,
  input  logic [W-1:0] ack_cnt,
  output logic [W-1:0] cnt_nx,
  output logic         en_nx,
  output logic         pend_nx
);

  logic [W-1:0] inc_v;
  logic [W-1:0] dec_v;
  logic [W-1:0] inc_masked;
  logic         cnt_zero;
  irq_mode_e    mode_e;

  assign inc_v      = cnt + W'(1);
  assign dec_v      = cnt - W'(1);
  assign inc_masked = inc_v & mask;
  assign cnt_zero   = (cnt == '0);
  assign mode_e     = irq_mode_e'(mode);

  always_comb begin
    cnt_nx  = cnt;
    en_nx   = en;
    pend_nx = pend;
    if (tick) begin
      case (mode_e)
        MODE_UP_LEVEL: begin
          if (en) begin
            cnt_nx  = inc_masked;
            pend_nx = (inc_masked >= thresh);
          end
        end
        MODE_UP_WRAP0: begin
          if (en) begin
            if (inc_v >= thresh) begin
              cnt_nx  = '0;
              pend_nx = 1'b1;
            end else begin
              cnt_nx = inc_v;
            end
          end
        end
        MODE_UP_ONESHOT: begin
          if (en) begin
            cnt_nx = inc_v;
            if (inc_v == thresh) begin
              pend_nx = 1'b1;
              en_nx   = 1'b0;
            end
          end
        end
        MODE_UP_WINDOW: begin
          if (en) begin
            cnt_nx = inc_v;
            if (inc_v == fire_cnt) pend_nx = 1'b1;
            else if (inc_v == ack_cnt) pend_nx = 1'b0;
          end
        end
        MODE_DN_STOP: begin
          if (en && !cnt_zero) begin
            cnt_nx = dec_v;
            if (dec_v == '0) pend_nx = 1'b1;
          end
        end
        MODE_DN_ONESHOT: begin
          if (en) begin
            if (cnt_zero) begin
              pend_nx = 1'b1;
              en_nx   = 1'b0;
            end else begin
              cnt_nx = dec_v;
            end
          end
        end
        MODE_DN_FREE: begin
          cnt_nx = dec_v;
          if (cnt_zero && en) pend_nx = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cyc_irq_cmd.sv
// Applies a register-write command on top of the tick result; writes win.
module cyc_irq_cmd
  import cyc_irq_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         wr_en,
  input  logic [2:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] reload,
  input  logic         en,
  input  logic         pend,
  input  logic [W-1:0] step_cnt,
  input  logic         step_en,
  input  logic         step_pend,
  output logic [W-1:0] cnt_nx,
  output logic [W-1:0] reload_nx,
  output logic         en_nx,
  output logic         pend_nx
);

  irq_cmd_e sel_e;
  assign sel_e = irq_cmd_e'(wr_sel);

  always_comb begin
    cnt_nx    = step_cnt;
    reload_nx = reload;
    en_nx     = step_en;
    pend_nx   = step_pend;
    if (wr_en) begin
      cnt_nx  = cnt;
      en_nx   = en;
      pend_nx = pend;
      case (sel_e)
        CMD_SET_CNT:    cnt_nx    = wr_data;
        CMD_SET_RELOAD: reload_nx = wr_data;
        CMD_SET_EN:     en_nx     = wr_data[0];
        CMD_SET_PEND:   pend_nx   = wr_data[0];
        CMD_LOAD:       cnt_nx    = reload;
        CMD_ACK:        pend_nx   = 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] thresh_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] fire_cnt_i,
  input  logic [W-1:0] ack_cnt_i,
  output logic         irq_o,
  output logic [W-1:0] count_o,
  output logic         enable_o
);

  logic [W-1:0] cnt_q, reload_q;
  logic         en_q, pend_q;
  logic [W-1:0] s_cnt, n_cnt, n_reload;
  logic         s_en, s_pend, n_en, n_pend;

  cyc_irq_step #(.W(W)) u_step (
    .tick     (tick_i),
    .mode     (mode_i),
    .cnt      (cnt_q),
    .en       (en_q),
    .pend     (pend_q),
    .thresh   (thresh_i),
    .mask     (mask_i),
    .fire_cnt (fire_cnt_i),
    .ack_cnt  (ack_cnt_i),
    .cnt_nx   (s_cnt),
    .en_nx    (s_en),
    .pend_nx  (s_pend)
  );

  cyc_irq_cmd #(.W(W)) u_cmd (
    .wr_en     (wr_en_i),
    .wr_sel    (wr_sel_i),
    .wr_data   (wr_data_i),
    .cnt       (cnt_q),
    .reload    (reload_q),
    .en        (en_q),
    .pend      (pend_q),
    .step_cnt  (s_cnt),
    .step_en   (s_en),
    .step_pend (s_pend),
    .cnt_nx    (n_cnt),
    .reload_nx (n_reload),
    .en_nx     (n_en),
    .pend_nx   (n_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      cnt_q    <= n_cnt;
      reload_q <= n_reload;
      en_q     <= n_en;
      pend_q   <= n_pend;
    end
  end

  assign irq_o    = pend_q;
  assign count_o  = cnt_q;
  assign enable_o = en_q;

endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         wr_en_i,
  input logic [2:0]   wr_sel_i,
  input logic [W-1:0] wr_data_i,
  input logic [2:0]   mode_i,
  input logic [W-1:0] thresh_i,
  input logic         irq_o,
  input logic [W-1:0] count_o,
  input logic         enable_o
);

  logic tk;
  assign tk = tick_i && !wr_en_i;

  p_write_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd0) |=> count_o == $past(wr_data_i));

  p_oneshot_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && mode_i == 3'd2 && enable_o && (count_o + W'(1)) == thresh_i)
    |=> (!enable_o && irq_o));

  p_stop_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && mode_i == 3'd4 && count_o == '0) |=> count_o == '0);

  p_zero_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && mode_i == 3'd5 && enable_o && count_o == '0)
    |=> (irq_o && !enable_o && count_o == '0));

  p_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && mode_i == 3'd6 && count_o == '0)
    |=> (count_o == '1 && irq_o == ($past(irq_o) || $past(enable_o))));

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && mode_i < 3'd6 && !enable_o) |=> ($stable(count_o) && $stable(irq_o)));

  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd5) |=> !irq_o);

  p_idle_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (tk && mode_i == 3'd7) |=> ($stable(count_o) && $stable(irq_o) && $stable(enable_o)));

endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .mode_i    (mode_i),
  .thresh_i  (thresh_i),
  .irq_o     (irq_o),
  .count_o   (count_o),
  .enable_o  (enable_o)
);

// File: tb/cyc_irq_timer_tb.sv
module cyc_irq_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_sel_i = 3'd0;
  logic [15:0] wr_data_i = 16'd0;
  logic [2:0]  mode_i = 3'd0;
  logic [15:0] thresh_i = 16'd0;
  logic [15:0] mask_i = 16'hFFFF;
  logic [15:0] fire_cnt_i = 16'd0;
  logic [15:0] ack_cnt_i = 16'd0;
  logic        irq_o;
  logic [15:0] count_o;
  logic        enable_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_irq_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .mode_i(mode_i),
    .thresh_i(thresh_i), .mask_i(mask_i), .fire_cnt_i(fire_cnt_i),
    .ack_cnt_i(ack_cnt_i), .irq_o(irq_o), .count_o(count_o), .enable_o(enable_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic setup(input logic [2:0] m, input logic [15:0] c, input logic en);
    mode_i = m;
    wr(3'd3, 16'd0);
    wr(3'd0, c);
    wr(3'd2, {15'd0, en});
  endtask

  task automatic t_reset;
    check("R1", "count", count_o, 0);
    check("R1", "enable", enable_o, 0);
    check("R1", "irq", irq_o, 0);
    wr(3'd4, 16'd0);
    check("R1", "reload value", count_o, 0);
  endtask

  task automatic t_up_level;
    thresh_i = 16'h000C; mask_i = 16'h000F;
    setup(3'd0, 16'd0, 1'b1);
    ticks(11);
    check("R3", "count below", count_o, 11);
    check("R3", "irq below", irq_o, 0);
    ticks(1);
    check("R3", "irq at thresh", irq_o, 1);
    ticks(3);
    check("R3", "count top", count_o, 15);
    ticks(1);
    check("R3", "masked wrap", count_o, 0);
    check("R3", "irq after wrap", irq_o, 0);
    mask_i = 16'hFFFF;
  endtask

  task automatic t_up_wrap0;
    thresh_i = 16'd5;
    setup(3'd1, 16'd0, 1'b1);
    ticks(4);
    check("R4", "irq early", irq_o, 0);
    ticks(1);
    check("R4", "irq fire", irq_o, 1);
    check("R4", "count reset", count_o, 0);
    wr(3'd5, 16'd0);
    check("R11", "ack", irq_o, 0);
    ticks(5);
    check("R4", "refire", irq_o, 1);
  endtask

  task automatic t_up_oneshot;
    thresh_i = 16'd3;
    setup(3'd2, 16'd0, 1'b1);
    ticks(3);
    check("R5", "irq", irq_o, 1);
    check("R5", "enable cleared", enable_o, 0);
    wr(3'd5, 16'd0);
    ticks(5);
    check("R5", "count held", count_o, 3);
    check("R5", "no refire", irq_o, 0);
  endtask

  task automatic t_up_window;
    fire_cnt_i = 16'd4; ack_cnt_i = 16'd8;
    setup(3'd3, 16'd0, 1'b1);
    ticks(4);
    check("R6", "fire", irq_o, 1);
    ticks(3);
    check("R6", "held", irq_o, 1);
    ticks(1);
    check("R6", "self clear", irq_o, 0);
    check("R6", "count", count_o, 8);
  endtask

  task automatic t_dn_stop;
    setup(3'd4, 16'd3, 1'b1);
    ticks(3);
    check("R7", "fire", irq_o, 1);
    check("R7", "count", count_o, 0);
    wr(3'd5, 16'd0);
    ticks(2);
    check("R7", "stays zero", count_o, 0);
    check("R7", "no refire", irq_o, 0);
    setup(3'd4, 16'd5, 1'b0);
    ticks(10);
    check("R10", "frozen count", count_o, 5);
    check("R10", "no irq", irq_o, 0);
  endtask

  task automatic t_dn_oneshot;
    setup(3'd5, 16'd5, 1'b1);
    ticks(5);
    check("R8", "count zero", count_o, 0);
    check("R8", "no irq yet", irq_o, 0);
    ticks(1);
    check("R8", "fire", irq_o, 1);
    check("R8", "enable cleared", enable_o, 0);
    check("R8", "count", count_o, 0);
  endtask

  task automatic t_dn_free;
    setup(3'd6, 16'd1, 1'b0);
    ticks(1);
    check("R9", "counts disabled", count_o, 0);
    ticks(1);
    check("R9", "wrap disabled", count_o, 16'hFFFF);
    check("R9", "no irq disabled", irq_o, 0);
    setup(3'd6, 16'd2, 1'b1);
    ticks(2);
    check("R9", "no irq at zero", irq_o, 0);
    ticks(1);
    check("R9", "wrap", count_o, 16'hFFFF);
    check("R9", "irq", irq_o, 1);
  endtask

  task automatic t_write_prio;
    mask_i = 16'hFFFF; thresh_i = 16'hFFFF;
    setup(3'd0, 16'd0, 1'b1);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd0; wr_data_i = 16'd5;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    check("R2", "write beats tick", count_o, 5);
    wr(3'd1, 16'h1234);
    wr(3'd4, 16'd0);
    check("R11", "reload copy", count_o, 16'h1234);
    wr(3'd3, 16'd1);
    check("R2", "pending write", irq_o, 1);
  endtask

  task automatic t_idle;
    setup(3'd7, 16'd9, 1'b1);
    ticks(4);
    check("R12", "count", count_o, 9);
    check("R12", "irq", irq_o, 0);
    check("R12", "enable", enable_o, 1);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up_level();
    t_up_wrap0();
    t_up_oneshot();
    t_up_window();
    t_dn_stop();
    t_dn_oneshot();
    t_dn_free();
    t_write_prio();
    t_idle();
    done = 1'b1;
    summary();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

endmodule